// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic cell of the kind repeated across a reconfigurable fabric. Two four-input lookup tables (F and G) and one three-input lookup table (H) compute arbitrary Boolean functions, with the truth tables held in a configuration register. H can take its inputs from the F and G results or straight from the four control inputs. This lets one cell build any single function of five variables, or two independent four-input functions plus a third three-input one.

Two combinational outputs pick among the generator results. Two storage elements can each capture a generator result. Each one has its own choice of clock edge, clock enable, set-or-reset value, and response to a global and a local set/reset. A storage element that is not in use passes a chosen control input straight to its output. The whole configuration is written as one parallel word while `cfg_load` is high. The storage elements start from their set/reset value after loading.

The configuration word is the packed record `cell_cfg_t` from `lcell_pkg`. The first listed field sits in the most significant bits. The fields, in order:
- `f_tt[15:0]`
- `g_tt[15:0]`
- `h_tt[7:0]`
- `ha_gen`, `ha_src[1:0]`, `hb_gen`, `hb_src[1:0]`, `hc_src[1:0]`
- `x_sel[1:0]`, `y_sel[1:0]`
- `ff[1:0]`, where `ff[1]` is higher and drives `yq`, and `ff[0]` drives `xq`.

Each `ff` entry holds, in order: `used`, `d_sel[1:0]`, `neg_edge`, `ce_on`, `ce_src[1:0]`, `sr_src[1:0]`, `sr_val`, `glob_en`, `loc_en`, `byp_src[1:0]`.

Top module: `cfg_logic_cell`

## Requirements
- R1: Synchronous reset clears the whole configuration register to zero. With zero configuration and `ctl` = 0, all four outputs are 0. On a rising clock edge with `cfg_load` high, the register takes `cfg_data`. With `cfg_load` low, it holds its value whatever `cfg_data` does.
- R2: The F result is `f_tt[f_in]` and the G result is `g_tt[g_in]`. The input value is the bit index, with `f_in[0]`/`g_in[0]` least significant.
- R3: The H result is `h_tt[{hC,hB,hA}]`, where:
  - hA is the F result when `ha_gen`=1, and otherwise `ctl[ha_src]`;
  - hB is the G result when `hb_gen`=1, and otherwise `ctl[hb_src]`;
  - hC is `ctl[hc_src]`.
- R4: `x` and `y` are combinational. A select code of 0 gives F, 1 gives G, and 2 or 3 gives H. `x` uses `x_sel` and `y` uses `y_sel`.
- R5: With `f_in`=`g_in`=v[3:0], `ha_gen`=`hb_gen`=1, `ctl[hc_src]`=v[4] and `h_tt`=8'hCA, output H equals {`g_tt`,`f_tt`}[v] for every 5-bit v.
- R6: A storage element updates on the rising clock edge when its `neg_edge`=0 and on the falling edge when `neg_edge`=1. It captures the generator chosen by `d_sel`, using the R4 encoding.
- R7: With `ce_on`=1, a storage element captures data only when `ctl[ce_src]` is high and otherwise holds. With `ce_on`=0, it captures on every active edge.
- R8: With `loc_en`=1 and `ctl[sr_src]` high, the next active edge loads `sr_val`. This takes priority over data and acts whether the clock enable is high or low. It has no effect between edges.
- R9: With `glob_en`=1, a high `gsr` forces the storage element to `sr_val` at once, without a clock edge and regardless of clock enable. With `glob_en`=0, `gsr` has no effect.
- R10: While `cfg_load` is high, every active edge loads the storage element with the `sr_val` of the incoming word and ignores data. After loading, the output therefore starts at that value.
- R11: With `used`=0, `xq` (or `yq`) equals `ctl[byp_src]` of the matching `ff` entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, shared by both storage elements |
| rst | input | 1 | Synchronous active-high reset of the configuration register |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_data | input | CFG_WIDTH (80) | Parallel configuration word |
| gsr | input | 1 | Global asynchronous set/reset line |
| f_in | input | 4 | Inputs of generator F |
| g_in | input | 4 | Inputs of generator G |
| ctl | input | 4 | Control inputs: H extra inputs, enables, local set/reset, bypass |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Storage element 0 output, or bypass |
| yq | output | 1 | Storage element 1 output, or bypass |

## Verification
Some properties are checked on every clock through assertions:
- configuration writes and holds;
- holding under a low clock enable;
- local set/reset landing on `sr_val`;
- `gsr` pinning a storage element.

The rising-edge forms of these are covered. The lookup-table contents and the five-input cascade can only be shown by the bench's scenarios, which sweep every input combination. So can the falling-edge capture, the asynchronous timing of `gsr` between edges, the initial value after loading, and the bypass path.

// File: rtl/cfg_logic_cell.sv
package lcell_pkg;
  localparam int LUT_K  = 4;
  localparam int H_K    = 3;
  localparam int CTL_N  = 4;
  localparam int CTL_W  = $clog2(CTL_N);
  localparam int SEL_W  = 2;
  localparam int NUM_FF = 2;

  typedef struct packed {
    logic             used;
    logic [SEL_W-1:0] d_sel;
    logic             neg_edge;
    logic             ce_on;
    logic [CTL_W-1:0] ce_src;
    logic [CTL_W-1:0] sr_src;
    logic             sr_val;
    logic             glob_en;
    logic             loc_en;
    logic [CTL_W-1:0] byp_src;
  } ff_cfg_t;

  typedef struct packed {
    logic [2**LUT_K-1:0]  f_tt;
    logic [2**LUT_K-1:0]  g_tt;
    logic [2**H_K-1:0]    h_tt;
    logic                 ha_gen;
    logic [CTL_W-1:0]     ha_src;
    logic                 hb_gen;
    logic [CTL_W-1:0]     hb_src;
    logic [CTL_W-1:0]     hc_src;
    logic [SEL_W-1:0]     x_sel;
    logic [SEL_W-1:0]     y_sel;
    ff_cfg_t [NUM_FF-1:0] ff;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  // Generator select: 0 -> F, 1 -> G, 2/3 -> H
  function automatic logic pick_gen(input logic [SEL_W-1:0] sel,
                                    input logic f, input logic g, input logic h);
    case (sel)
      2'd0:    return f;
      2'd1:    return g;
      default: return h;
    endcase
  endfunction
endpackage

module lcell_lut #(
  parameter int K = 4
) (
  input  logic [2**K-1:0] tt,
  input  logic [K-1:0]    idx,
  output logic            o
);
  assign o = tt[idx];
endmodule

module lcell_ff
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             gsr,
  input  logic             load,
  input  logic             load_val,
  input  ff_cfg_t          fc,
  input  logic             f,
  input  logic             g,
  input  logic             h,
  input  logic [CTL_N-1:0] ctl,
  output logic             q_o
);
  logic d, ce, lsr, gsr_hit, upd, upd_val;
  logic q_p, q_n;

  always_comb begin
    d       = pick_gen(fc.d_sel, f, g, h);
    ce      = fc.ce_on ? ctl[fc.ce_src] : 1'b1;
    lsr     = fc.loc_en & ctl[fc.sr_src];
    gsr_hit = gsr & fc.glob_en;
    upd     = load | lsr | ce;
    upd_val = load ? load_val : (lsr ? fc.sr_val : d);
  end

  always_ff @(posedge clk or posedge gsr_hit) begin
    if (gsr_hit)  q_p <= fc.sr_val;
    else if (upd) q_p <= upd_val;
  end

  always_ff @(negedge clk or posedge gsr_hit) begin
    if (gsr_hit)  q_n <= fc.sr_val;
    else if (upd) q_n <= upd_val;
  end

  assign q_o = fc.used ? (fc.neg_edge ? q_n : q_p) : ctl[fc.byp_src];
endmodule

module cfg_logic_cell
  import lcell_pkg::*;
#(
  parameter int CFG_WIDTH = CFG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_load,
  input  logic [CFG_WIDTH-1:0] cfg_data,
  input  logic                 gsr,
  input  logic [LUT_K-1:0]     f_in,
  input  logic [LUT_K-1:0]     g_in,
  input  logic [CTL_N-1:0]     ctl,
  output logic                 x,
  output logic                 y,
  output logic                 xq,
  output logic                 yq
);
  cell_cfg_t        cfg_q;
  cell_cfg_t        cfg_in;
  logic             f_o, g_o, h_o;
  logic [H_K-1:0]   h_idx;
  logic [NUM_FF-1:0] ff_q;

  assign cfg_in = cell_cfg_t'(cfg_data);

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_in;
  end

  lcell_lut #(.K(LUT_K)) u_lut_f (.tt(cfg_q.f_tt), .idx(f_in), .o(f_o));
  lcell_lut #(.K(LUT_K)) u_lut_g (.tt(cfg_q.g_tt), .idx(g_in), .o(g_o));

  always_comb begin
    h_idx[0] = cfg_q.ha_gen ? f_o : ctl[cfg_q.ha_src];
    h_idx[1] = cfg_q.hb_gen ? g_o : ctl[cfg_q.hb_src];
    h_idx[2] = ctl[cfg_q.hc_src];
  end

  lcell_lut #(.K(H_K)) u_lut_h (.tt(cfg_q.h_tt), .idx(h_idx), .o(h_o));

  assign x = pick_gen(cfg_q.x_sel, f_o, g_o, h_o);
  assign y = pick_gen(cfg_q.y_sel, f_o, g_o, h_o);

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    lcell_ff u_ff (
      .clk     (clk),
      .gsr     (gsr),
      .load    (cfg_load),
      .load_val(cfg_in.ff[i].sr_val),
      .fc      (cfg_q.ff[i]),
      .f       (f_o),
      .g       (g_o),
      .h       (h_o),
      .ctl     (ctl),
      .q_o     (ff_q[i])
    );
  end

  assign xq = ff_q[0];
  assign yq = ff_q[1];
endmodule

module cfg_logic_cell_chk
  import lcell_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [CFG_W-1:0] cfg_data,
  input logic             gsr,
  input logic [CTL_N-1:0] ctl,
  input cell_cfg_t        cfg_q,
  input logic             xq,
  input logic             yq
);
  logic [NUM_FF-1:0] qv;
  assign qv = {yq, xq};

  // R1: a write strobe stores the presented word
  a_r1_cfg_write: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (CFG_W'(cfg_q) == $past(cfg_data)));

  // R1: without a strobe the configuration does not move
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_q));

  for (genvar i = 0; i < NUM_FF; i++) begin : g_chk
    ff_cfg_t fc;
    assign fc = cfg_q.ff[i];

    // R7: enable low, no set/reset -> rising-edge element holds
    a_r7_ce_hold: assert property (@(posedge clk) disable iff (rst)
      (!cfg_load && fc.used && !fc.neg_edge && fc.ce_on && !ctl[fc.ce_src]
       && !(fc.loc_en && ctl[fc.sr_src]) && !(gsr && fc.glob_en))
      |=> ($stable(qv[i]) || (gsr && fc.glob_en)));

    // R8: local set/reset lands on sr_val at the next rising edge
    a_r8_local_sr: assert property (@(posedge clk) disable iff (rst)
      (!cfg_load && fc.used && !fc.neg_edge && fc.loc_en && ctl[fc.sr_src])
      |=> (qv[i] == fc.sr_val));

    // R9: global set/reset pins the element while high
    a_r9_gsr_force: assert property (@(posedge clk) disable iff (rst)
      (gsr && fc.glob_en && fc.used) |-> (qv[i] == fc.sr_val));
  end
endmodule

bind cfg_logic_cell cfg_logic_cell_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_load(cfg_load),
  .cfg_data(cfg_data),
  .gsr     (gsr),
  .ctl     (ctl),
  .cfg_q   (cfg_q),
  .xq      (xq),
  .yq      (yq)
);

// File: tb/cfg_logic_cell_bench.sv
`timescale 1ns/1ps
module cfg_logic_cell_bench;
  import lcell_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_load = 1'b0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic             gsr = 1'b0;
  logic [3:0]       f_in = '0;
  logic [3:0]       g_in = '0;
  logic [3:0]       ctl = '0;
  logic             x, y, xq, yq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cfg_logic_cell u_cfg_logic_cell (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_data(cfg_data), .gsr(gsr),
    .f_in(f_in), .g_in(g_in), .ctl(ctl), .x(x), .y(y), .xq(xq), .yq(yq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  // returns 2 ns after a rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic load_cfg(input cell_cfg_t c);
    tick();
    cfg_data = c;
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    chk("R1 reset x", x, 1'b0);
    chk("R1 reset y", y, 1'b0);
    chk("R1 reset xq", xq, 1'b0);
    chk("R1 reset yq", yq, 1'b0);
    ctl = 4'b0001;
    #1;
    chk("R11 reset bypass xq", xq, 1'b1);
    chk("R11 reset bypass yq", yq, 1'b1);
    ctl = '0;
  endtask

  task automatic t_luts();
    cell_cfg_t c = '0;
    c.f_tt  = 16'($urandom());
    c.g_tt  = 16'($urandom());
    c.x_sel = 2'd0;
    c.y_sel = 2'd1;
    load_cfg(c);
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i);
      g_in = 4'(15 - i);
      #1;
      chk("R2 F table on x", x, c.f_tt[i]);
      chk("R4 G table on y", y, c.g_tt[15 - i]);
    end
    cfg_data = ~CFG_W'(c);
    tick();
    f_in = 4'd5;
    #1;
    chk("R1 config held without strobe", x, c.f_tt[5]);
  endtask

  task automatic t_hgen();
    cell_cfg_t c = '0;
    logic [2:0] hi;
    c.h_tt   = 8'($urandom());
    c.ha_src = 2'd0;
    c.hb_src = 2'd1;
    c.hc_src = 2'd3;
    c.x_sel  = 2'd2;
    c.y_sel  = 2'd3;
    load_cfg(c);
    for (int i = 0; i < 16; i++) begin
      ctl = 4'(i);
      #1;
      hi = {ctl[3], ctl[1], ctl[0]};
      chk("R3 H from control inputs", x, c.h_tt[hi]);
      chk("R4 select code 3 gives H", y, c.h_tt[hi]);
    end
    c.f_tt   = 16'($urandom());
    c.g_tt   = 16'($urandom());
    c.ha_gen = 1'b1;
    c.hb_gen = 1'b1;
    c.y_sel  = 2'd0;
    load_cfg(c);
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i);
      g_in = ~4'(i);
      ctl  = 4'(i);
      #1;
      hi = {ctl[3], c.g_tt[g_in], c.f_tt[f_in]};
      chk("R3 H fed by F and G", x, c.h_tt[hi]);
    end
    ctl = '0;
  endtask

  task automatic t_five();
    cell_cfg_t c = '0;
    logic [31:0] tt;
    tt       = $urandom();
    c.f_tt   = tt[15:0];
    c.g_tt   = tt[31:16];
    c.h_tt   = 8'hCA;
    c.ha_gen = 1'b1;
    c.hb_gen = 1'b1;
    c.hc_src = 2'd2;
    c.x_sel  = 2'd2;
    load_cfg(c);
    for (int v = 0; v < 32; v++) begin
      f_in = 4'(v);
      g_in = 4'(v);
      ctl  = {1'b0, 1'(v >> 4), 2'b00};
      #1;
      chk("R5 five-input function", x, tt[v]);
    end
    ctl = '0;
  endtask

  task automatic t_edges();
    cell_cfg_t c = '0;
    c.f_tt           = 16'hAAAA;
    c.g_tt           = 16'hAAAA;
    c.ff[0].used     = 1'b1;
    c.ff[0].d_sel    = 2'd0;
    c.ff[1].used     = 1'b1;
    c.ff[1].d_sel    = 2'd1;
    c.ff[1].neg_edge = 1'b1;
    f_in = '0;
    g_in = '0;
    load_cfg(c);
    f_in = 4'd1;
    g_in = 4'd1;
    #3;
    chk("R6 falling element captured", yq, 1'b1);
    chk("R6 rising element waits", xq, 1'b0);
    tick();
    chk("R6 rising element captured", xq, 1'b1);
  endtask

  task automatic t_ce();
    cell_cfg_t c = '0;
    c.f_tt         = 16'hAAAA;
    c.ff[0].used   = 1'b1;
    c.ff[0].ce_on  = 1'b1;
    c.ff[0].ce_src = 2'd1;
    f_in = '0;
    load_cfg(c);
    ctl  = 4'b0000;
    f_in = 4'd1;
    tick();
    chk("R7 enable low holds", xq, 1'b0);
    ctl = 4'b0010;
    tick();
    chk("R7 enable high captures", xq, 1'b1);
    ctl  = 4'b0000;
    f_in = 4'd0;
    tick();
    chk("R7 enable low holds one", xq, 1'b1);
  endtask

  task automatic t_lsr();
    cell_cfg_t c = '0;
    c.f_tt         = 16'hAAAA;
    c.ff[0].used   = 1'b1;
    c.ff[0].ce_on  = 1'b1;
    c.ff[0].ce_src = 2'd1;
    c.ff[0].loc_en = 1'b1;
    c.ff[0].sr_src = 2'd2;
    c.ff[0].sr_val = 1'b1;
    load_cfg(c);
    ctl  = 4'b0010;
    f_in = 4'd0;
    tick();
    chk("R8 data path before set", xq, 1'b0);
    ctl = 4'b0100;
    #1;
    chk("R8 no effect between edges", xq, 1'b0);
    tick();
    chk("R8 set with enable low", xq, 1'b1);
    ctl = 4'b0010;
    tick();
    chk("R8 data resumes", xq, 1'b0);
    ctl = 4'b0110;
    tick();
    chk("R8 set beats data", xq, 1'b1);
    ctl = '0;
  endtask

  task automatic t_gsr();
    cell_cfg_t c = '0;
    c.f_tt          = 16'hAAAA;
    c.g_tt          = 16'hAAAA;
    c.ff[0].used    = 1'b1;
    c.ff[0].ce_on   = 1'b1;
    c.ff[0].ce_src  = 2'd1;
    c.ff[0].glob_en = 1'b1;
    c.ff[0].sr_val  = 1'b1;
    c.ff[1]         = c.ff[0];
    c.ff[1].glob_en = 1'b0;
    c.ff[1].d_sel   = 2'd1;
    load_cfg(c);
    ctl  = 4'b0010;
    f_in = '0;
    g_in = '0;
    tick();
    chk("R9 cleared by data x", xq, 1'b0);
    chk("R9 cleared by data y", yq, 1'b0);
    ctl = 4'b0000;
    #1;
    gsr = 1'b1;
    #1;
    chk("R9 asynchronous force", xq, 1'b1);
    chk("R9 ignored when disabled", yq, 1'b0);
    tick();
    chk("R9 held across edge", xq, 1'b1);
    gsr = 1'b0;
    tick();
    chk("R9 value kept after release", xq, 1'b1);
    chk("R9 disabled element untouched", yq, 1'b0);
  endtask

  task automatic t_load_init();
    cell_cfg_t c = '0;
    c.f_tt           = 16'hFFFF;
    c.ff[0].used     = 1'b1;
    c.ff[1].used     = 1'b1;
    c.ff[1].neg_edge = 1'b1;
    load_cfg(c);
    #1;
    chk("R10 init value x ignores data", xq, 1'b0);
    chk("R10 init value y ignores data", yq, 1'b0);
    tick();
    chk("R10 data after load x", xq, 1'b1);
    chk("R10 data after load y", yq, 1'b1);
    c.ff[0].sr_val = 1'b1;
    c.ff[1].sr_val = 1'b1;
    c.f_tt         = 16'h0000;
    load_cfg(c);
    #1;
    chk("R10 init one x", xq, 1'b1);
    chk("R10 init one y", yq, 1'b1);
    c.ff[0].sr_val = 1'b0;
    c.ff[1].sr_val = 1'b0;
    c.f_tt         = 16'hFFFF;
    load_cfg(c);
    #1;
    chk("R10 reload to zero x", xq, 1'b0);
    chk("R10 reload to zero y", yq, 1'b0);
  endtask

  task automatic t_bypass();
    cell_cfg_t c = '0;
    c.ff[0].byp_src = 2'd3;
    c.ff[1].byp_src = 2'd2;
    load_cfg(c);
    for (int i = 0; i < 16; i++) begin
      ctl = 4'(i);
      #1;
      chk("R11 bypass xq", xq, ctl[3]);
      chk("R11 bypass yq", yq, ctl[2]);
    end
    ctl = '0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_luts();
        t_hgen();
        t_five();
        t_edges();
        t_ce();
        t_lsr();
        t_gsr();
        t_load_init();
        t_bypass();
      end
      begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: act=running exp=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule